// File: doc/BRIEF.md
# Symmetric Half-Bridge On-Time Counter

This block times the two switches of a half-bridge from one up/down counter. While the high-side request is active the counter climbs from zero. When it reaches the current limit, or when the current-sense stop input terminates the pulse, it turns around. It then descends back to zero with the low-side request active. Both conduction intervals come from the same count, so they are equal to the clock cycle.

The limit is reloaded at the start of every high-side interval. While soft-start is active it is taken from the soft-start value input. Otherwise it is the fixed maximum on-time parameter. A high-side interval that ends on the limit outside soft-start is a limit hit. A run of such hits, one in each switching cycle, raises a latched fault once the run reaches the programmed threshold. The fault stops all switching until reset.

Switching begins on a start pulse and then runs without pause. The next high-side interval begins on the clock that follows the end of the low-side interval.

Top module: `ontime_updown_ctr`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, both gate requests and the fault flag are low.
- R2: From idle with no fault, a start input sampled high raises the high-side request on the next cycle. The two requests are never high together.
- R3: With current sense quiet, the high-side interval lasts exactly as many cycles as the limit value captured at its start.
- R4: A current-sense stop sampled high during a high-side cycle makes that cycle the last one of the interval. The next cycle is low-side.
- R5: Each low-side interval lasts exactly as many cycles as the high-side interval before it. The high-side request rises on the very next cycle, with no dead time.
- R6: At the start of each high-side interval the limit is captured. With soft-start active it is the soft-start value, and a value of 0 is taken as 1. With soft-start inactive it is the maximum on-time parameter. Later changes of either input do not affect an interval already running.
- R7: A limit hit in an interval that began with soft-start active does not count toward the fault, and it clears the hit run.
- R8: A limit hit in an interval that began with soft-start inactive adds one to the hit run. An interval ended by current sense clears the run. The fault is raised when the run reaches the threshold input, and a threshold of 0 acts as 1.
- R9: The fault flag stays high until reset. On the edge that raises it, both requests go low, and start is then ignored.
- R10: When current sense and the limit end the same high-side cycle, the interval is treated as ended by current sense.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin switching from idle |
| cs_stop_i | input | 1 | Current-sense termination of the high-side interval |
| ss_active_i | input | 1 | Soft-start in progress |
| ss_limit_i | input | CW | Soft-start on-time limit, in cycles |
| fault_thr_i | input | FW | Number of consecutive limit hits that raises the fault |
| hs_req_o | output | 1 | High-side gate request |
| ls_req_o | output | 1 | Low-side gate request |
| fault_o | output | 1 | Latched limit-hit fault |

## Verification
A corrupted count or phase shows up within one switching period. It appears as a high-side width that differs from the captured limit, or as a low-side width that differs from the high-side width before it. A bad limit capture changes the next high-side width. A bad hit run shows as a fault raised one period early or late. A reference model tracks every interval length and the hit run, and the gate and fault outputs are compared against it on every cycle.

// File: rtl/ontime_updown_ctr.sv
module ontime_updown_ctr #(
  parameter int CW     = 8,
  parameter int MAX_ON = 48,
  parameter int FW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cs_stop_i,
  input  logic          ss_active_i,
  input  logic [CW-1:0] ss_limit_i,
  input  logic [FW-1:0] fault_thr_i,
  output logic          hs_req_o,
  output logic          ls_req_o,
  output logic          fault_o
);
  localparam logic [CW-1:0] MAX_L = CW'(MAX_ON);
  localparam logic [CW-1:0] ONE   = CW'(1);

  typedef enum logic [1:0] {IDLE, UP, DOWN} ph_t;

  ph_t           ph_q;
  logic [CW-1:0] cnt_q, lim_q;
  logic          ss_cyc_q;
  logic [FW-1:0] hits_q;
  logic          fault_q;

  logic [CW:0]   cnt_inc;
  logic [CW-1:0] reload;
  logic          end_cs, end_lim, hit_cnt, trip;
  logic [FW:0]   hits_nx;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign reload  = ss_active_i ? ((ss_limit_i == '0) ? ONE : ss_limit_i) : MAX_L;
  assign end_cs  = (ph_q == UP) && cs_stop_i;
  assign end_lim = (ph_q == UP) && !cs_stop_i && (cnt_inc >= {1'b0, lim_q});
  assign hit_cnt = end_lim && !ss_cyc_q;
  assign hits_nx = {1'b0, hits_q} + 1'b1;
  assign trip    = hit_cnt && (hits_nx >= {1'b0, fault_thr_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= IDLE;
      cnt_q    <= '0;
      lim_q    <= ONE;
      ss_cyc_q <= 1'b0;
      hits_q   <= '0;
      fault_q  <= 1'b0;
    end else begin
      case (ph_q)
        IDLE: begin
          cnt_q <= '0;
          if (start_i && !fault_q) begin
            ph_q     <= UP;
            lim_q    <= reload;
            ss_cyc_q <= ss_active_i;
          end
        end
        UP: begin
          cnt_q <= cnt_inc[CW-1:0];
          if (end_cs || end_lim) ph_q <= trip ? IDLE : DOWN;
          if (end_cs || (end_lim && ss_cyc_q)) hits_q <= '0;
          else if (hit_cnt && !trip) hits_q <= hits_nx[FW-1:0];
          if (trip) fault_q <= 1'b1;
        end
        DOWN: begin
          if (cnt_q == ONE) begin
            ph_q     <= UP;
            cnt_q    <= '0;
            lim_q    <= reload;
            ss_cyc_q <= ss_active_i;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: ph_q <= IDLE;
      endcase
    end
  end

  assign hs_req_o = (ph_q == UP);
  assign ls_req_o = (ph_q == DOWN);
  assign fault_o  = fault_q;
endmodule

module ontime_updown_ctr_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          cs_stop_i,
  input logic          hs_req_o,
  input logic          ls_req_o,
  input logic          fault_o,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] lim_q
);
  // R2
  excl_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_req_o && ls_req_o));
  // R2
  start_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_req_o && !ls_req_o && !fault_o && start_i) |=> hs_req_o);
  // R3
  lim_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_req_o && ({1'b0, cnt_q} + 1'b1 >= {1'b0, lim_q})) |=> !hs_req_o);
  // R4
  cs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_req_o && cs_stop_i) |=> (ls_req_o && !fault_o));
  // R5
  no_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_req_o) |-> hs_req_o);
  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);
  // R9
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!hs_req_o && !ls_req_o));
endmodule

bind ontime_updown_ctr ontime_updown_ctr_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_stop_i(cs_stop_i),
  .hs_req_o(hs_req_o), .ls_req_o(ls_req_o), .fault_o(fault_o),
  .cnt_q(cnt_q), .lim_q(lim_q)
);

// File: tb/test_ontime_updown_ctr.sv
`timescale 1ns/1ps
module test_ontime_updown_ctr;
  localparam int CW = 8, MAX_ON = 48, FW = 3;

  logic clk = 0, rst_n = 0, start = 0, cs = 0, ss_act = 0;
  logic [CW-1:0] ss_val = 0;
  logic [FW-1:0] thr = 7;
  logic hs, ls, flt;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ontime_updown_ctr #(.CW(CW), .MAX_ON(MAX_ON), .FW(FW)) i_ontime_updown_ctr (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cs_stop_i(cs),
    .ss_active_i(ss_act), .ss_limit_i(ss_val), .fault_thr_i(thr),
    .hs_req_o(hs), .ls_req_o(ls), .fault_o(flt));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: mode 0 idle, 1 high, 2 low
  int m_mode, m_hi, m_lo, m_lim, m_hits;
  bit m_ssc, m_flt;
  function automatic int pick_lim();
    if (!ss_act) return MAX_ON;
    return (ss_val == 0) ? 1 : int'(ss_val);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_hi = 0; m_lo = 0; m_lim = 1; m_hits = 0; m_ssc = 0; m_flt = 0;
    end else if (m_mode == 0) begin
      if (start && !m_flt) begin
        m_mode = 1; m_hi = 0; m_lim = pick_lim(); m_ssc = ss_act;
      end
    end else if (m_mode == 1) begin
      m_hi++;
      if (cs || m_hi >= m_lim) begin
        m_lo = m_hi;
        if (cs || m_ssc) m_hits = 0;
        else begin
          m_hits++;
          if (m_hits >= int'(thr)) m_flt = 1;
        end
        m_mode = m_flt ? 0 : 2;
      end
    end else begin
      m_lo--;
      if (m_lo == 0) begin
        m_mode = 1; m_hi = 0; m_lim = pick_lim(); m_ssc = ss_act;
      end
    end
  end

  // per-cycle comparison and interval measurement
  event hi_start, hi_done;
  int hcnt = 0, lcnt = 0, last_hi = 0;
  bit p_hs = 0, p_ls = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(hs == (m_mode == 1), "R2 high request", hs, m_mode == 1);
      chk(ls == (m_mode == 2), "R5 low request", ls, m_mode == 2);
      chk(flt == m_flt, "R8 fault", flt, m_flt);
      if (hs && !p_hs) -> hi_start;
      if (hs) hcnt++;
      if (!hs && p_hs) begin last_hi = hcnt; hcnt = 0; -> hi_done; end
      if (ls) lcnt++;
      if (!ls && p_ls) begin
        chk(lcnt == last_hi, "R5 low width", lcnt, last_hi);
        chk(hs == 1'b1, "R5 no dead time", hs, 1);
        lcnt = 0;
      end
    end else begin
      hcnt = 0; lcnt = 0;
    end
    p_hs = hs; p_ls = ls;
  end

  task automatic cs_at(input int k);
    @(hi_start);
    repeat (k - 1) @(negedge clk);
    cs = 1;
    @(negedge clk);
    cs = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    chk(!hs && !ls && !flt, "R1 reset state", {hs, ls, flt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!hs && !ls && !flt, "R1 after reset", {hs, ls, flt}, 0);

    ss_act = 1; ss_val = 5;
    start = 1; @(negedge clk); start = 0;
    chk(hs, "R2 start", hs, 1);
    @(hi_done); chk(last_hi == 5, "R6 soft-start limit", last_hi, 5);
    ss_val = 9;
    @(hi_done); chk(last_hi == 9, "R6 reloaded limit", last_hi, 9);
    ss_val = 0;
    @(hi_done); chk(last_hi == 1, "R6 zero limit", last_hi, 1);
    chk(!flt, "R7 no fault in soft-start", flt, 0);

    thr = 2; ss_act = 0;
    @(hi_done); chk(last_hi == MAX_ON, "R3 max on-time", last_hi, MAX_ON);
    chk(!flt, "R8 one hit", flt, 0);
    cs_at(10);
    @(hi_done); chk(last_hi == 10, "R4 current-sense stop", last_hi, 10);
    @(hi_done); chk(!flt, "R8 run cleared by cs", flt, 0);
    cs_at(MAX_ON);
    @(hi_done); chk(last_hi == MAX_ON && !flt, "R10 cs priority", flt, 0);
    @(hi_done); chk(!flt, "R8 run restarted", flt, 0);
    @(hi_done); chk(flt, "R8 fault at threshold", flt, 1);
    chk(!ls, "R9 low off at fault", ls, 0);
    start = 1;
    repeat (5) @(negedge clk);
    start = 0;
    chk(!hs && !ls && flt, "R9 start ignored, fault held", {hs, ls, flt}, 1);

    rst_n = 0; repeat (2) @(negedge clk);
    chk(!flt, "R9 reset clears fault", flt, 0);
    rst_n = 1; thr = 0;
    @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    @(hi_done);
    chk(last_hi == MAX_ON, "R3 width", last_hi, MAX_ON);
    chk(flt, "R8 threshold zero", flt, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule